// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel that copies elements between one fixed device register address and a memory buffer. Every element is one read followed by one write on a shared memory-master port. Data goes memory to device or device to memory, depending on a direction bit captured at start. Each element waits for the device request line. The memory-side address steps by the element width after each element.

The channel has two run modes. In one-shot mode the four descriptor values come from input ports and are captured when the mode is written. In chained mode the channel reads four-word descriptors from memory, starting at a head pointer. The low bits of each descriptor's link word decide whether to follow the chain and whether to raise an interrupt. Software starts, stops and observes the channel through a mode write strobe, a mode readback, a 2-bit state code and pulsed done, interrupt and error outputs.

Top module: `dma_chan_top`

## Requirements
- R1: While reset is asserted, and after it is released, state_o is 0, mode_o is 0, mem_req_o is low, and done_o, irq_o and err_o are low.
- R2: Writing mode 2 (one-shot) while idle captures the four one-shot ports. The channel then performs count elements. Each element is a read followed by a write that carries the read data, and the memory-side address steps by the width in bytes. The channel then pulses done_o in the cycle it returns to idle, and mode_o reads 0.
- R3: With dir_i = 1 each element reads the memory address and writes the device address. With dir_i = 0 it reads the device address and writes the memory address. The device address never changes.
- R4: Size word bits [13:12] select the width: 3 is 1 byte (mem_width_o 0), 2 is 2 bytes (mem_width_o 1), 0 is 4 bytes (mem_width_o 2). The count is bits [10:0].
- R5: A count above 0x3FF with a 1-byte or 2-byte width is an error. 0x3FF itself is accepted. A count of 0 completes with no data access.
- R6: Writing mode 1 (chained) while idle fetches a descriptor at the head pointer as four 4-byte reads: +0 device address, +4 memory address, +8 size, +12 link.
- R7: Link bit 0 pulses irq_o when the descriptor finishes. In chained mode link bit 1 makes the channel fetch the next descriptor at the link word with bits [1:0] cleared; otherwise the run ends. In one-shot mode link bit 1 is ignored.
- R8: state_o is 0 idle, 1 while fetching a descriptor, 2 while waiting for the device, 3 while accessing data. No memory request is made when idle.
- R9: Writing mode 0 while the channel is busy stops it at the next edge. The channel goes idle with mode 0, issues no further access and gives no done pulse. This holds even when dev_req_i rises in the same cycle.
- R10: A bus error response, or width code 1 in a descriptor, pulses err_o and irq_o together, clears the mode to 0 and returns the channel to idle. No done pulse is given.
- R11: A mode write of 1 or 2 while the channel is busy is ignored. The mode and the transfer in progress are unchanged.
- R12: In the waiting state the channel holds, with no memory request, until dev_req_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 2 | Mode value: 0 off, 1 chained, 2 one-shot |
| dir_i | input | 1 | 1 memory to device, 0 device to memory; captured at start |
| os_dev_addr_i | input | 32 | One-shot device address |
| os_mem_addr_i | input | 32 | One-shot memory address |
| os_size_i | input | 32 | One-shot size word (width code and count) |
| os_next_i | input | 32 | One-shot link word (flags in [1:0]) |
| chain_head_i | input | 32 | Address of the first chained descriptor |
| dev_req_i | input | 1 | Device requests one element |
| mem_req_o | output | 1 | Memory access request, held until response |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 32 | Write data |
| mem_width_o | output | 2 | Access size, log2 of bytes |
| mem_rsp_i | input | 1 | Response for the pending request |
| mem_rdata_i | input | 32 | Read data with the response |
| mem_err_i | input | 1 | Bus error with the response |
| mode_o | output | 2 | Current mode |
| state_o | output | 2 | Channel state code |
| done_o | output | 1 | Run completed, one-cycle pulse |
| irq_o | output | 1 | Interrupt, one-cycle pulse |
| err_o | output | 1 | Error, one-cycle pulse |

## Verification
The two functions that can fall on the same edge are the abort write and the start of an element. The device request can rise in the same cycle that software writes mode 0 while the channel waits. The bench drives mode_we_i with value 0 and raises dev_req_i at the same falling edge. It then requires that the channel is idle with mode 0 one cycle later, that no read ever reaches the memory responder, and that no done pulse appears. Every bus transaction is matched against a queue of expected accesses built from the requirements. The match covers the state code shown while each access is made.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_CHAIN = 2'd1;
  localparam logic [1:0] MODE_ONE   = 2'd2;

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_DESC = 2'd1;
  localparam logic [1:0] ST_WAIT = 2'd2;
  localparam logic [1:0] ST_XFER = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_RD, S_WR, S_END
  } ctrl_st_e;
endpackage

// File: rtl/dma_size_decode.sv
module dma_size_decode #(
  parameter int CW = 11
) (
  input  logic [1:0]    wcode_i,
  input  logic [CW-1:0] cnt_i,
  output logic [1:0]    shift_o,
  output logic          bad_o
);
  logic narrow, rsvd;

  always_comb begin
    narrow  = 1'b0;
    rsvd    = 1'b0;
    shift_o = 2'd2;
    case (wcode_i)
      2'b11: begin shift_o = 2'd0; narrow = 1'b1; end
      2'b10: begin shift_o = 2'd1; narrow = 1'b1; end
      2'b00: shift_o = 2'd2;
      default: rsvd = 1'b1;
    endcase
    // narrow widths allow one bit less of count
    bad_o = rsvd | (narrow & cnt_i[CW-1]);
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DW   = 32,
  parameter int CW   = 11,
  parameter int WPOS = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_we_i,
  input  logic [1:0]    mode_wdata_i,
  input  logic          dir_i,
  input  logic [DW-1:0] os_dev_addr_i,
  input  logic [DW-1:0] os_mem_addr_i,
  input  logic [DW-1:0] os_size_i,
  input  logic [DW-1:0] os_next_i,
  input  logic [DW-1:0] chain_head_i,
  input  logic          dev_req_i,
  output logic [1:0]    dec_wcode_o,
  output logic [CW-1:0] dec_cnt_o,
  input  logic [1:0]    dec_shift_i,
  input  logic          dec_bad_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [1:0]    mem_width_o,
  input  logic          mem_rsp_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_err_i,
  output logic [1:0]    mode_o,
  output logic [1:0]    state_o,
  output logic          done_o,
  output logic          irq_o,
  output logic          err_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  ctrl_st_e      st_q;
  logic [1:0]    mode_q, wcode_q, idx_q;
  logic          dir_q, done_q, irq_q, err_q;
  logic [DW-1:0] dev_q, mem_q, next_q, ptr_q, data_q;
  logic [CW-1:0] cnt_q;
  logic          abort_w, start_w, fail_w;
  logic          unused_size;

  assign unused_size = ^{os_size_i[DW-1:WPOS+2], os_size_i[WPOS-1:CW]};

  assign abort_w = mode_we_i && (mode_wdata_i == MODE_OFF) && (st_q != S_IDLE);
  assign start_w = mode_we_i && (st_q == S_IDLE) &&
                   ((mode_wdata_i == MODE_CHAIN) || (mode_wdata_i == MODE_ONE));
  assign fail_w  = (mem_req_o && mem_rsp_i && mem_err_i) ||
                   (start_w && (mode_wdata_i == MODE_ONE) && dec_bad_i) ||
                   ((st_q == S_FETCH) && mem_rsp_i && (idx_q == 2'd3) && dec_bad_i);

  // decoder sees the one-shot word while idle, the held fields otherwise
  assign dec_wcode_o = (st_q == S_IDLE) ? os_size_i[WPOS+1:WPOS] : wcode_q;
  assign dec_cnt_o   = (st_q == S_IDLE) ? os_size_i[CW-1:0]      : cnt_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_width_o = dec_shift_i;
    case (st_q)
      S_FETCH: begin
        mem_req_o   = 1'b1;
        mem_addr_o  = ptr_q + DW'({idx_q, 2'b00});
        mem_width_o = 2'd2;
      end
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = dir_q ? mem_q : dev_q;
      end
      S_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = dir_q ? dev_q : mem_q;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (st_q)
      S_IDLE:  state_o = ST_IDLE;
      S_FETCH: state_o = ST_DESC;
      S_WAIT:  state_o = ST_WAIT;
      default: state_o = ST_XFER;
    endcase
  end

  assign mem_wdata_o = data_q;
  assign mode_o      = mode_q;
  assign done_o      = done_q;
  assign irq_o       = irq_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      mode_q  <= MODE_OFF;
      wcode_q <= '0;
      idx_q   <= '0;
      dir_q   <= 1'b0;
      dev_q   <= '0;
      mem_q   <= '0;
      next_q  <= '0;
      ptr_q   <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
      if (abort_w) begin
        st_q   <= S_IDLE;
        mode_q <= MODE_OFF;
      end else if (fail_w) begin
        st_q   <= S_IDLE;
        mode_q <= MODE_OFF;
        err_q  <= 1'b1;
        irq_q  <= 1'b1;
      end else begin
        case (st_q)
          S_IDLE: if (start_w) begin
            mode_q <= mode_wdata_i;
            dir_q  <= dir_i;
            if (mode_wdata_i == MODE_ONE) begin
              dev_q   <= os_dev_addr_i;
              mem_q   <= os_mem_addr_i;
              wcode_q <= os_size_i[WPOS+1:WPOS];
              cnt_q   <= os_size_i[CW-1:0];
              next_q  <= os_next_i;
              st_q    <= (os_size_i[CW-1:0] == '0) ? S_END : S_WAIT;
            end else begin
              ptr_q <= chain_head_i;
              idx_q <= '0;
              st_q  <= S_FETCH;
            end
          end
          S_FETCH: if (mem_rsp_i) begin
            idx_q <= idx_q + 2'd1;
            case (idx_q)
              2'd0: dev_q <= mem_rdata_i;
              2'd1: mem_q <= mem_rdata_i;
              2'd2: begin
                wcode_q <= mem_rdata_i[WPOS+1:WPOS];
                cnt_q   <= mem_rdata_i[CW-1:0];
              end
              default: begin
                next_q <= mem_rdata_i;
                st_q   <= (cnt_q == '0) ? S_END : S_WAIT;
              end
            endcase
          end
          S_WAIT: if (dev_req_i) st_q <= S_RD;
          S_RD: if (mem_rsp_i) begin
            data_q <= mem_rdata_i;
            st_q   <= S_WR;
          end
          S_WR: if (mem_rsp_i) begin
            cnt_q <= cnt_q - CNT_ONE;
            mem_q <= mem_q + (DW'(1) << dec_shift_i);
            st_q  <= (cnt_q == CNT_ONE) ? S_END : S_WAIT;
          end
          S_END: begin
            irq_q <= next_q[0];
            if ((mode_q == MODE_CHAIN) && next_q[1]) begin
              ptr_q <= {next_q[DW-1:2], 2'b00};
              idx_q <= '0;
              st_q  <= S_FETCH;
            end else begin
              st_q   <= S_IDLE;
              mode_q <= MODE_OFF;
              done_q <= 1'b1;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_i && !mode_we_i) |=> (mem_req_o && $stable(mem_addr_o))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE) |-> !mem_req_o); // R8
  AST_DONE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_o == ST_IDLE && mode_o == MODE_OFF && !err_o)); // R2
  AST_ERR_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (irq_o && state_o == ST_IDLE && mode_o == MODE_OFF)); // R10
  AST_FETCH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DESC) |-> (mem_req_o && !mem_we_o && mem_width_o == 2'd2)); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_WAIT && !dev_req_i && !mode_we_i) |=> (state_o == ST_WAIT)); // R12
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_IDLE && state_o != ST_XFER && mode_we_i && mode_wdata_i != MODE_OFF)
      |=> (mode_o == $past(mode_o))); // R11
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_IDLE && mode_we_i && mode_wdata_i == MODE_OFF)
      |=> (state_o == ST_IDLE && !done_o)); // R9
endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_we_i,
  input  logic [1:0]  mode_wdata_i,
  input  logic        dir_i,
  input  logic [31:0] os_dev_addr_i,
  input  logic [31:0] os_mem_addr_i,
  input  logic [31:0] os_size_i,
  input  logic [31:0] os_next_i,
  input  logic [31:0] chain_head_i,
  input  logic        dev_req_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic [1:0]  mem_width_o,
  input  logic        mem_rsp_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_err_i,
  output logic [1:0]  mode_o,
  output logic [1:0]  state_o,
  output logic        done_o,
  output logic        irq_o,
  output logic        err_o
);
  localparam int DW   = 32;
  localparam int CW   = 11;
  localparam int WPOS = 12;

  logic [1:0]    dec_wcode, dec_shift;
  logic [CW-1:0] dec_cnt;
  logic          dec_bad;

  dma_size_decode #(.CW(CW)) u_dec (
    .wcode_i (dec_wcode),
    .cnt_i   (dec_cnt),
    .shift_o (dec_shift),
    .bad_o   (dec_bad)
  );

  dma_chan_ctrl #(.DW(DW), .CW(CW), .WPOS(WPOS)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_we_i     (mode_we_i),
    .mode_wdata_i  (mode_wdata_i),
    .dir_i         (dir_i),
    .os_dev_addr_i (os_dev_addr_i),
    .os_mem_addr_i (os_mem_addr_i),
    .os_size_i     (os_size_i),
    .os_next_i     (os_next_i),
    .chain_head_i  (chain_head_i),
    .dev_req_i     (dev_req_i),
    .dec_wcode_o   (dec_wcode),
    .dec_cnt_o     (dec_cnt),
    .dec_shift_i   (dec_shift),
    .dec_bad_i     (dec_bad),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_width_o   (mem_width_o),
    .mem_rsp_i     (mem_rsp_i),
    .mem_rdata_i   (mem_rdata_i),
    .mem_err_i     (mem_err_i),
    .mode_o        (mode_o),
    .state_o       (state_o),
    .done_o        (done_o),
    .irq_o         (irq_o),
    .err_o         (err_o)
  );
endmodule

// File: tb/dma_chan_top_tb.sv
`timescale 1ns/1ps
module dma_chan_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 1'b0;
  logic [1:0] mode_wdata = 2'd0;
  logic dir = 1'b0;
  logic [31:0] os_dev = '0, os_mem = '0, os_size = '0, os_next = '0, head = '0;
  logic dev_req = 1'b1;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0] mem_width;
  logic mem_rsp = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic mem_err = 1'b0;
  logic [1:0] mode_o, state_o;
  logic done_o, irq_o, err_o;

  always #10 clk = ~clk;

  dma_chan_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
    .dir_i(dir), .os_dev_addr_i(os_dev), .os_mem_addr_i(os_mem), .os_size_i(os_size),
    .os_next_i(os_next), .chain_head_i(head), .dev_req_i(dev_req),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_width_o(mem_width), .mem_rsp_i(mem_rsp),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err), .mode_o(mode_o),
    .state_o(state_o), .done_o(done_o), .irq_o(irq_o), .err_o(err_o)
  );

  int vectors = 0;
  int misses = 0;
  int n_done = 0, n_irq = 0, n_err = 0;
  logic [31:0] mem [logic [31:0]];
  logic [67:0] expq [$];
  logic        err_en = 1'b0;
  logic [31:0] err_at = '0;
  bit          finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] sz(input logic [1:0] wc, input int unsigned c);
    return (32'(wc) << 12) | 32'(c);
  endfunction

  // entry: {fetch, we, width, addr, data}
  task automatic add_data(input bit d, input logic [31:0] dev, input logic [31:0] ma,
                          input logic [1:0] sh, input int unsigned cnt);
    for (int unsigned k = 0; k < cnt; k++) begin
      logic [31:0] m, ra, wa, v;
      m  = ma + (32'(k) << sh);
      ra = d ? m : dev;
      wa = d ? dev : m;
      v  = rd(ra);
      expq.push_back({1'b0, 1'b0, sh, ra, v});
      expq.push_back({1'b0, 1'b1, sh, wa, v});
    end
  endtask

  task automatic add_fetch(input logic [31:0] p);
    for (int i = 0; i < 4; i++) expq.push_back({1'b1, 1'b0, 2'd2, p + 32'(4*i), rd(p + 32'(4*i))});
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] dv, input logic [31:0] ma,
                          input logic [31:0] s, input logic [31:0] n);
    mem[a] = dv; mem[a+4] = ma; mem[a+8] = s; mem[a+12] = n;
  endtask

  // memory responder and per-access comparison against the expected queue
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp = 1'b0;
    end else if (mem_rsp) begin
      mem_rsp = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2 unexpected access", {31'd0, mem_we, mem_addr}, 64'd0);
      end else begin
        logic [67:0] e;
        e = expq.pop_front();
        chk(mem_we == e[66] && mem_width == e[65:64] && mem_addr == e[63:32],
            e[67] ? "R6 fetch access" : "R3 R4 data access",
            {29'd0, mem_we, mem_width, mem_addr}, {29'd0, e[66], e[65:64], e[63:32]});
        chk(state_o == (e[67] ? 2'd1 : 2'd3), "R8 state during access", 64'(state_o), e[67] ? 64'd1 : 64'd3);
        if (mem_we) chk(mem_wdata == e[31:0], "R2 write data", 64'(mem_wdata), 64'(e[31:0]));
      end
      mem_err = err_en && (mem_addr == err_at);
      if (mem_we) begin
        if (!mem_err) mem[mem_addr] = mem_wdata;
        mem_rdata = '0;
      end else begin
        mem_rdata = rd(mem_addr);
      end
      mem_rsp = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_done += int'(done_o);
      n_irq  += int'(irq_o);
      n_err  += int'(err_o);
    end
  end

  task automatic write_mode(input logic [1:0] v);
    @(negedge clk);
    mode_we = 1'b1;
    mode_wdata = v;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic clear_counts();
    n_done = 0; n_irq = 0; n_err = 0;
  endtask

  task automatic finish_run(input int ed, input int ei, input int ee, input string req);
    int n;
    n = 0;
    while (state_o != 2'd0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    @(negedge clk);
    chk(n_done == ed, {req, " done pulses"}, 64'(n_done), 64'(ed));
    chk(n_irq == ei,  {req, " irq pulses"},  64'(n_irq),  64'(ei));
    chk(n_err == ee,  {req, " err pulses"},  64'(n_err),  64'(ee));
    chk(expq.size() == 0, {req, " accesses left"}, 64'(expq.size()), 64'd0);
    chk(mode_o == 2'd0, {req, " mode cleared"}, 64'(mode_o), 64'd0);
    expq.delete();
  endtask

  task automatic one_shot(input bit d, input logic [31:0] dv, input logic [31:0] ma,
                          input logic [31:0] s, input logic [31:0] n);
    dir = d; os_dev = dv; os_mem = ma; os_size = s; os_next = n;
    clear_counts();
    write_mode(2'd2);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    misses++;
    vectors++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, during and after reset
    chk(state_o == 0 && mode_o == 0 && !mem_req && !done_o && !irq_o && !err_o,
        "R1 in reset", {60'd0, state_o, mode_o}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(state_o == 0 && mode_o == 0 && !mem_req, "R1 after reset", {60'd0, state_o, mode_o}, 64'd0);

    // R2 R3 R4 R7: one-shot, memory to device, 4-byte, ends with irq
    add_data(1'b1, 32'h8000_0000, 32'h0000_0100, 2'd2, 3);
    one_shot(1'b1, 32'h8000_0000, 32'h0000_0100, sz(2'd0, 3), 32'h1);
    finish_run(1, 1, 0, "R2 R7 one-shot 4B");

    // R3 R4: device to memory, 1-byte, no irq
    add_data(1'b0, 32'h8000_0004, 32'h0000_0203, 2'd0, 4);
    one_shot(1'b0, 32'h8000_0004, 32'h0000_0203, sz(2'd3, 4), 32'h0);
    finish_run(1, 0, 0, "R3 R4 one-shot 1B");

    // R4 R7: 2-byte, link bit 1 set but one-shot ends anyway
    add_data(1'b1, 32'h8000_0008, 32'h0000_0302, 2'd1, 2);
    one_shot(1'b1, 32'h8000_0008, 32'h0000_0302, sz(2'd2, 2), 32'h0000_5003);
    finish_run(1, 1, 0, "R7 one-shot ignores follow");

    // R5: count 0 completes without access
    one_shot(1'b1, 32'h8000_000C, 32'h0000_0400, sz(2'd0, 0), 32'h0);
    finish_run(1, 0, 0, "R5 zero count");

    // R5 R10: 1-byte count 0x400 rejected
    one_shot(1'b1, 32'h8000_000C, 32'h0000_0400, sz(2'd3, 32'h400), 32'h1);
    finish_run(0, 1, 1, "R5 R10 count over limit");

    // R5: 2-byte count 0x3FF accepted
    add_data(1'b0, 32'h8000_0010, 32'h0001_0000, 2'd1, 32'h3FF);
    one_shot(1'b0, 32'h8000_0010, 32'h0001_0000, sz(2'd2, 32'h3FF), 32'h0);
    finish_run(1, 0, 0, "R5 count at limit");

    // R6 R7: three-descriptor chain with mixed widths
    put_desc(32'h1000, 32'h8000_0020, 32'h2000, sz(2'd0, 2), 32'h1100 | 32'h3);
    put_desc(32'h1100, 32'h8000_0024, 32'h3001, sz(2'd3, 3), 32'h1200 | 32'h2);
    put_desc(32'h1200, 32'h8000_0028, 32'h4002, sz(2'd2, 2), 32'h1);
    add_fetch(32'h1000); add_data(1'b1, 32'h8000_0020, 32'h2000, 2'd2, 2);
    add_fetch(32'h1100); add_data(1'b1, 32'h8000_0024, 32'h3001, 2'd0, 3);
    add_fetch(32'h1200); add_data(1'b1, 32'h8000_0028, 32'h4002, 2'd1, 2);
    dir = 1'b1; head = 32'h1000; clear_counts();
    write_mode(2'd1);
    finish_run(1, 2, 0, "R6 R7 chain");

    // R10: reserved width code 1 in a fetched descriptor
    put_desc(32'h1300, 32'h8000_0030, 32'h5000, sz(2'd1, 2), 32'h0);
    add_fetch(32'h1300);
    dir = 1'b0; head = 32'h1300; clear_counts();
    write_mode(2'd1);
    finish_run(0, 1, 1, "R10 reserved width");

    // R10: bus error on the second element read
    add_data(1'b1, 32'h8000_0040, 32'h6000, 2'd2, 1);
    expq.push_back({1'b0, 1'b0, 2'd2, 32'h6004, rd(32'h6004)});
    err_en = 1'b1; err_at = 32'h6004;
    one_shot(1'b1, 32'h8000_0040, 32'h6000, sz(2'd0, 3), 32'h0);
    finish_run(0, 1, 1, "R10 bus error");
    err_en = 1'b0;

    // R12 R11: hold in wait without device request; busy start ignored
    dev_req = 1'b0;
    add_data(1'b1, 32'h8000_0050, 32'h7000, 2'd2, 2);
    one_shot(1'b1, 32'h8000_0050, 32'h7000, sz(2'd0, 2), 32'h0);
    repeat (20) @(negedge clk);
    chk(state_o == 2'd2 && !mem_req, "R12 waiting holds", {62'd0, state_o}, 64'd2);
    write_mode(2'd1);
    chk(mode_o == 2'd2, "R11 busy start ignored", 64'(mode_o), 64'd2);
    chk(state_o == 2'd2, "R11 state unchanged", 64'(state_o), 64'd2);
    dev_req = 1'b1;
    finish_run(1, 0, 0, "R11 R12 run after hold");

    // R9: abort lands on the same edge as the device request
    dev_req = 1'b0;
    one_shot(1'b1, 32'h8000_0060, 32'h7100, sz(2'd0, 2), 32'h1);
    repeat (3) @(negedge clk);
    chk(state_o == 2'd2, "R9 in wait before abort", 64'(state_o), 64'd2);
    mode_we = 1'b1; mode_wdata = 2'd0; dev_req = 1'b1;
    @(negedge clk);
    mode_we = 1'b0;
    chk(state_o == 2'd0 && mode_o == 2'd0 && !mem_req, "R9 abort to idle",
        {60'd0, state_o, mode_o}, 64'd0);
    repeat (5) @(negedge clk);
    chk(n_done == 0 && n_irq == 0, "R9 no done after abort", 64'(n_done + n_irq), 64'd0);
    chk(expq.size() == 0 && state_o == 2'd0, "R9 no access after abort", 64'(state_o), 64'd0);

    // R2: a fresh run after abort works
    add_data(1'b0, 32'h8000_0070, 32'h7200, 2'd2, 1);
    one_shot(1'b0, 32'h8000_0070, 32'h7200, sz(2'd0, 1), 32'h1);
    finish_run(1, 1, 0, "R2 run after abort");

    report();
  end
endmodule